// File: doc/BRIEF.md
# Thread-Loadable Global Branch Predictor

This block is the conditional branch predictor of one processing unit in a speculatively multithreaded chip. It is a plain global two-level predictor: the global history register selects one 2-bit saturating counter, whose upper bit gives the direction. When a branch resolves, that counter is trained and the outcome is shifted into the history. The history register does not run on from one thread to the next. Whenever the unit begins a thread, or re-runs one after a misspeculation, it asks a shared per-thread history table for that thread's stored history and loads the reply. When a thread finishes, the block sends out its history so the table can store it.

The table answers a fixed number of cycles after each request. It answers requests in the order they were made. While any request is still outstanding, the block has no trustworthy history. In that window every prediction is answered not-taken and marked invalid, and every resolved branch is dropped. If the unit issues a second request before the first reply comes back, only the reply to the newest request is loaded. With the 14-bit history setting, the counter store is 4 KB (16384 counters). The default setting is smaller.

Top module: `thread_gpred`

## Requirements
- R1: After reset, every counter holds 1 (weakly not-taken), the history is zero and no load is outstanding. A first prediction is therefore valid and not-taken, and a first write-back carries zero.
- R2: Each cycle with `pred_req_i` high produces exactly one cycle of `pred_rsp_o` on the next cycle. When no load is outstanding, `pred_ok_o` is 1 and `pred_taken_o` is 1 exactly when the counter selected by the current history holds 2 or 3.
- R3: A resolved taken branch increments the selected counter, stopping at 3. A resolved not-taken branch decrements it, stopping at 0.
- R4: After a resolved branch, the history becomes {history[HIST_W-2:0], outcome}. The outcome enters at the least significant bit.
- R5: `hist_rd_o` is high in the same cycle as `thr_start_i` or `thr_restart_i`. From the following cycle, a load is outstanding until the table's reply arrives on `hist_rd_valid_i`.
- R6: While a load is outstanding, a prediction request is answered with `pred_ok_o` = 0 and `pred_taken_o` = 0.
- R7: While a load is outstanding, a resolved branch changes neither the counters nor the history.
- R8: One cycle after `thr_end_i`, `hist_wr_o` is high. `hist_wr_data_o` then carries the history as it stood after that cycle's own update.
- R9: A restart discards the history built up so far. The history becomes exactly the value the table returns.
- R10: If a prediction and an update happen in the same cycle, the prediction uses the counter value from before the update.
- R11: While several requests are outstanding, only the reply that brings the count to zero is loaded. Earlier replies are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_start_i | input | 1 | Thread begins on this unit |
| thr_restart_i | input | 1 | Thread re-runs after a misspeculation |
| thr_end_i | input | 1 | Thread has finished |
| hist_rd_o | output | 1 | History request to the shared table |
| hist_rd_valid_i | input | 1 | Table reply valid |
| hist_rd_data_i | input | HIST_W | History returned by the table |
| hist_wr_o | output | 1 | Write-back of the finished thread's history |
| hist_wr_data_o | output | HIST_W | History to write back |
| pred_req_i | input | 1 | Prediction request |
| pred_rsp_o | output | 1 | Prediction response |
| pred_ok_o | output | 1 | Response is based on a loaded history |
| pred_taken_o | output | 1 | Predicted direction, 1 means taken |
| res_valid_i | input | 1 | A branch has resolved |
| res_taken_i | input | 1 | Resolved outcome, 1 means taken |

## Verification
`hist_rd_o` follows the start and restart inputs within the same cycle. The bench reads it 1 ns after driving them. A prediction response and a write-back appear on the cycle after their request. The bench's driver stamps every expected response and write-back with its due cycle number. The monitor fails any item that shows up on another cycle, shows up without having been expected, or never shows up. A reply from the table takes effect at the clock edge where it arrives, so the model changes its history at that same step. This lets later predictions and write-backs check when a load or a drop took effect.

// File: rtl/tgp_pkg.sv
package tgp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_dir(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tgp_ctr_table.sv
module tgp_ctr_table
  import tgp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr_next(ctr_q[wr_idx_i], wr_taken_i);
    end
  end

  // read sees pre-update state
  assign rd_taken_o = ctr_dir(ctr_q[rd_idx_i]);
endmodule

// File: rtl/tgp_load_track.sv
module tgp_load_track #(
  parameter int OUTS_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic rv_i,
  output logic pending_o,
  output logic accept_o
);
  logic [OUTS_W-1:0] outs_q, outs_d;

  always_comb begin
    outs_d = outs_q;
    if (rd_i && !rv_i) outs_d = outs_q + OUTS_W'(1);
    else if (!rd_i && rv_i && outs_q != '0) outs_d = outs_q - OUTS_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outs_q <= '0;
    else         outs_q <= outs_d;
  end

  assign pending_o = (outs_q != '0);
  // only the reply to the newest request is used
  assign accept_o  = rv_i && !rd_i && (outs_q == OUTS_W'(1));
endmodule

// File: rtl/tgp_hist_reg.sv
module tgp_hist_reg #(
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HIST_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o,
  output logic [HIST_W-1:0] hist_next_o
);
  logic [HIST_W-1:0] hist_q, shifted;

  if (HIST_W > 1) begin : g_wide
    assign shifted = {hist_q[HIST_W-2:0], taken_i};
  end else begin : g_single
    assign shifted = taken_i;
  end

  always_comb begin
    hist_next_o = hist_q;
    if (load_i)       hist_next_o = load_data_i;
    else if (shift_i) hist_next_o = shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_next_o;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/thread_gpred.sv
module thread_gpred #(
  parameter int HIST_W = 10,
  parameter int OUTS_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_start_i,
  input  logic              thr_restart_i,
  input  logic              thr_end_i,
  output logic              hist_rd_o,
  input  logic              hist_rd_valid_i,
  input  logic [HIST_W-1:0] hist_rd_data_i,
  output logic              hist_wr_o,
  output logic [HIST_W-1:0] hist_wr_data_o,
  input  logic              pred_req_i,
  output logic              pred_rsp_o,
  output logic              pred_ok_o,
  output logic              pred_taken_o,
  input  logic              res_valid_i,
  input  logic              res_taken_i
);
  logic              load_pend, load_acc, upd_en, ctr_taken;
  logic [HIST_W-1:0] hist_q, hist_d;
  logic              rsp_q, ok_q, tk_q, wr_q;
  logic [HIST_W-1:0] wr_data_q;

  assign hist_rd_o = thr_start_i | thr_restart_i;
  assign upd_en    = res_valid_i & ~load_pend;

  tgp_load_track #(.OUTS_W(OUTS_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (hist_rd_o),
    .rv_i      (hist_rd_valid_i),
    .pending_o (load_pend),
    .accept_o  (load_acc)
  );

  tgp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_acc),
    .load_data_i (hist_rd_data_i),
    .shift_i     (upd_en),
    .taken_i     (res_taken_i),
    .hist_o      (hist_q),
    .hist_next_o (hist_d)
  );

  tgp_ctr_table #(.IDX_W(HIST_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (hist_q),
    .rd_taken_o (ctr_taken),
    .wr_en_i    (upd_en),
    .wr_idx_i   (hist_q),
    .wr_taken_i (res_taken_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q     <= 1'b0;
      ok_q      <= 1'b0;
      tk_q      <= 1'b0;
      wr_q      <= 1'b0;
      wr_data_q <= '0;
    end else begin
      rsp_q <= pred_req_i;
      ok_q  <= pred_req_i & ~load_pend;
      tk_q  <= pred_req_i & ~load_pend & ctr_taken;
      wr_q  <= thr_end_i;
      if (thr_end_i) wr_data_q <= hist_d;
    end
  end

  assign pred_rsp_o     = rsp_q;
  assign pred_ok_o      = ok_q;
  assign pred_taken_o   = tk_q;
  assign hist_wr_o      = wr_q;
  assign hist_wr_data_o = wr_data_q;
endmodule

// File: rtl/tgp_checker.sv
module tgp_checker #(
  parameter int HIST_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pred_req_i,
  input logic              pred_rsp_o,
  input logic              pred_ok_o,
  input logic              pred_taken_o,
  input logic              thr_end_i,
  input logic              hist_wr_o,
  input logic              hist_rd_o,
  input logic              hist_rd_valid_i,
  input logic              pending,
  input logic [HIST_W-1:0] hist_q
);
  p_rsp_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i |=> pred_rsp_o);

  p_no_spurious_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_req_i |=> !pred_rsp_o);

  p_rd_sets_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_rd_o |=> pending);

  p_invalid_not_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_rsp_o && !pred_ok_o) |-> !pred_taken_o);

  p_idle_rsp_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_req_i && !pending) |=> pred_ok_o);

  p_hist_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && !hist_rd_valid_i) |=> $stable(hist_q));

  p_wr_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_end_i |=> hist_wr_o);
endmodule

bind thread_gpred tgp_checker #(.HIST_W(HIST_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .pred_req_i      (pred_req_i),
  .pred_rsp_o      (pred_rsp_o),
  .pred_ok_o       (pred_ok_o),
  .pred_taken_o    (pred_taken_o),
  .thr_end_i       (thr_end_i),
  .hist_wr_o       (hist_wr_o),
  .hist_rd_o       (hist_rd_o),
  .hist_rd_valid_i (hist_rd_valid_i),
  .pending         (load_pend),
  .hist_q          (hist_q)
);

// File: tb/sim_thread_gpred.sv
module sim_thread_gpred;
  localparam int HW    = 10;
  localparam int DEPTH = 1 << HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_start = 0, thr_restart = 0, thr_end = 0;
  logic hist_rd_o, hist_rd_valid = 0;
  logic [HW-1:0] hist_rd_data = '0;
  logic hist_wr_o;
  logic [HW-1:0] hist_wr_data_o;
  logic pred_req = 0, pred_rsp_o, pred_ok_o, pred_taken_o;
  logic res_valid = 0, res_taken = 0;

  always #2.5 clk = ~clk;

  thread_gpred #(.HIST_W(HW), .OUTS_W(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .thr_start_i(thr_start), .thr_restart_i(thr_restart), .thr_end_i(thr_end),
    .hist_rd_o(hist_rd_o), .hist_rd_valid_i(hist_rd_valid), .hist_rd_data_i(hist_rd_data),
    .hist_wr_o(hist_wr_o), .hist_wr_data_o(hist_wr_data_o),
    .pred_req_i(pred_req), .pred_rsp_o(pred_rsp_o), .pred_ok_o(pred_ok_o),
    .pred_taken_o(pred_taken_o), .res_valid_i(res_valid), .res_taken_i(res_taken)
  );

  typedef struct { int due; int ok; int tk; } pexp_t;
  typedef struct { int due; int h; } wexp_t;

  pexp_t pq[$];
  string ptag[$];
  wexp_t wq[$];
  string wtag[$];

  int checks = 0, errors = 0, cyc = 0;
  logic [1:0] m_ctr [DEPTH];
  logic [HW-1:0] m_hist = '0;
  int m_outs = 0;
  bit running = 0;

  task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin : mon
    pexp_t e;
    wexp_t w;
    string t;
    if (rst_n && running) begin
      if (pred_rsp_o) begin
        if (pq.size() == 0) chk(0, "R2", "unexpected pred_rsp_o", 1, 0);
        else begin
          e = pq.pop_front(); t = ptag.pop_front();
          chk(e.due == cyc, t, "pred cycle", cyc, e.due);
          chk(int'(pred_ok_o) == e.ok, t, "pred_ok_o", int'(pred_ok_o), e.ok);
          chk(int'(pred_taken_o) == e.tk, t, "pred_taken_o", int'(pred_taken_o), e.tk);
        end
      end else if (pq.size() != 0 && pq[0].due <= cyc) begin
        e = pq.pop_front(); t = ptag.pop_front();
        chk(0, t, "missing pred_rsp_o", 0, 1);
      end
      if (hist_wr_o) begin
        if (wq.size() == 0) chk(0, "R8", "unexpected hist_wr_o", 1, 0);
        else begin
          w = wq.pop_front(); t = wtag.pop_front();
          chk(w.due == cyc, t, "write-back cycle", cyc, w.due);
          chk(int'(hist_wr_data_o) == w.h, t, "hist_wr_data_o", int'(hist_wr_data_o), w.h);
        end
      end else if (wq.size() != 0 && wq[0].due <= cyc) begin
        w = wq.pop_front(); t = wtag.pop_front();
        chk(0, t, "missing hist_wr_o", 0, 1);
      end
    end
  end

  // driver + reference model
  task automatic step(input bit st, input bit rs, input bit en, input bit rq, input bit up,
                      input bit tk, input bit rv, input logic [HW-1:0] d, input string tag);
    bit pend, rd, acc, uok;
    logic [HW-1:0] nh;
    @(negedge clk);
    thr_start = st; thr_restart = rs; thr_end = en; pred_req = rq;
    res_valid = up; res_taken = tk; hist_rd_valid = rv; hist_rd_data = d;
    pend = (m_outs != 0);
    rd   = st | rs;
    acc  = rv && !rd && (m_outs == 1);
    uok  = up && !pend;
    if (rq) begin
      pq.push_back('{cyc + 1, int'(!pend), int'(!pend && m_ctr[m_hist][1])});
      ptag.push_back(tag);
    end
    nh = m_hist;
    if (uok) begin
      if (tk) m_ctr[m_hist] = (m_ctr[m_hist] == 2'd3) ? 2'd3 : m_ctr[m_hist] + 2'd1;
      else    m_ctr[m_hist] = (m_ctr[m_hist] == 2'd0) ? 2'd0 : m_ctr[m_hist] - 2'd1;
      nh = {m_hist[HW-2:0], tk};
    end
    if (acc) nh = d;
    if (en) begin
      wq.push_back('{cyc + 1, int'(nh)});
      wtag.push_back(tag);
    end
    m_hist = nh;
    m_outs = m_outs + int'(rd) - int'(rv);
    if (m_outs < 0) m_outs = 0;
    #1 chk(hist_rd_o === rd, "R5", "hist_rd_o", int'(hist_rd_o), int'(rd));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, '0, "R2");
  endtask

  task automatic reload(input logic [HW-1:0] v, input string tag);
    step(0, 1, 0, 0, 0, 0, 0, '0, tag);
    step(0, 0, 0, 0, 0, 0, 0, '0, tag);
    step(0, 0, 0, 0, 0, 0, 1, v, tag);
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    bit p0, p1, rd, rnd_st, rnd_rs;
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(pred_rsp_o == 0, "R1", "pred_rsp_o after reset", int'(pred_rsp_o), 0);
    chk(hist_wr_o == 0, "R1", "hist_wr_o after reset", int'(hist_wr_o), 0);
    chk(hist_rd_o == 0, "R1", "hist_rd_o after reset", int'(hist_rd_o), 0);
    running = 1;

    // R1: first prediction valid not-taken, first write-back zero
    step(0, 0, 0, 1, 0, 0, 0, '0, "R1");
    step(0, 0, 1, 0, 0, 0, 0, '0, "R1");
    idle(2);

    // R3: saturation at 0 on history 0 (not-taken keeps history 0)
    step(0, 0, 0, 0, 1, 0, 0, '0, "R3");
    step(0, 0, 0, 0, 1, 0, 0, '0, "R3");
    step(0, 0, 0, 0, 1, 0, 0, '0, "R3");
    step(0, 0, 0, 0, 1, 1, 0, '0, "R4");
    step(0, 0, 1, 0, 0, 0, 0, '0, "R4");  // history now 1
    reload(10'd0, "R9");
    step(0, 0, 0, 0, 1, 1, 0, '0, "R3");
    reload(10'd0, "R9");
    step(0, 0, 0, 1, 0, 0, 0, '0, "R3");  // counter 2 -> taken

    // R3: saturation at 3 on a loaded history
    step(1, 0, 0, 0, 0, 0, 0, '0, "R5");
    idle(1);
    step(0, 0, 0, 0, 0, 0, 1, 10'h2A5, "R5");
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 0, 1, 1, 0, '0, "R4");
      reload(10'h2A5, "R9");
    end
    step(0, 0, 0, 1, 0, 0, 0, '0, "R3");
    for (int i = 0; i < 2; i++) begin
      step(0, 0, 1, 0, 1, 0, 0, '0, "R8");
      reload(10'h2A5, "R9");
    end
    step(0, 0, 0, 1, 0, 0, 0, '0, "R3");
    step(0, 0, 1, 0, 0, 0, 0, '0, "R9");

    // R10: same-cycle predict and update
    step(0, 0, 0, 1, 1, 1, 0, '0, "R10");
    step(0, 0, 0, 1, 0, 0, 0, '0, "R10");
    reload(10'h2A5, "R10");
    step(0, 0, 0, 1, 1, 1, 0, '0, "R10");
    reload(10'h2A5, "R10");
    step(0, 0, 0, 1, 0, 0, 0, '0, "R10");

    // R6 / R7: pending window
    step(1, 0, 0, 0, 0, 0, 0, '0, "R5");
    step(0, 0, 0, 1, 1, 1, 0, '0, "R6");
    step(0, 0, 0, 1, 1, 0, 1, 10'h0F3, "R7");
    step(0, 0, 1, 1, 0, 0, 0, '0, "R7");

    // R11: two outstanding requests, only newest reply loads
    step(1, 0, 0, 0, 0, 0, 0, '0, "R11");
    step(0, 1, 0, 0, 0, 0, 0, '0, "R11");
    step(0, 0, 0, 1, 0, 0, 1, 10'h111, "R11");
    step(0, 0, 0, 0, 0, 0, 1, 10'h222, "R11");
    step(0, 0, 1, 1, 0, 0, 0, '0, "R11");

    // R8 / R4: end with same-cycle update
    step(0, 0, 1, 0, 1, 1, 0, '0, "R8");
    step(0, 0, 1, 0, 1, 0, 0, '0, "R4");
    idle(3);

    // random traffic against the model
    p0 = 0; p1 = 0;
    for (int k = 0; k < 4000; k++) begin
      rnd_st = ($urandom_range(0, 19) == 0);
      rnd_rs = !rnd_st && ($urandom_range(0, 29) == 0);
      rd = rnd_st | rnd_rs;
      step(rnd_st, rnd_rs, $urandom_range(0, 9) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0, p1,
           HW'($urandom_range(0, DEPTH - 1)), "R2");
      p1 = p0; p0 = rd;
    end
    step(0, 0, 0, 0, 0, 0, p1, '0, "R2");
    step(0, 0, 0, 0, 0, 0, p0, '0, "R2");
    idle(4);
    chk(pq.size() == 0, "R2", "unanswered predictions", pq.size(), 0);
    chk(wq.size() == 0, "R8", "missing write-backs", wq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule